// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block moves two-channel audio samples from a small tagged input queue onto a single serial data line. Its timing comes from the outside: a clock generator delivers one-cycle strobes for the rising and falling edges of the bit clock, and the frame clock level marks the channel (low for left, high for right). On the selected bit-clock strobe the block samples the frame clock, detects the start of each half-frame, pops the matching sample and shifts it out most significant bit first.

Three placements are supported in one datapath: standard (one bit clock between the frame clock transition and the MSB), left-justified (MSB on the first bit clock of the half-frame) and right-justified (LSB on the last bit clock of the half-frame). The sample width and the half-frame length are set independently, and every bit slot that carries no sample bit is sent as zero. A single enable starts the transmitter. Dropping the enable flushes the queue and silences the line.

Control is a state machine with five states. OFF holds the line low while enable is low. OFF goes to SYNC once enable is high. SYNC waits for the frame clock to turn low (a new left half-frame). Every half-frame start (from SYNC, LEAD, SHIFT or PAD) loads a word and enters LEAD when leading slots are due, or SHIFT directly when none are. LEAD emits zero slots and then moves to SHIFT. SHIFT emits sample bits and then moves to PAD. PAD emits zeros until the next half-frame starts. Any state returns to OFF when enable is low.

Top module: `stereo_ser_tx`

## Requirements
- R1: `word_sel` picks the sample width: 0 gives 16 bits, 1 gives 24, 2 gives 32, and the reserved value 3 is handled as 32. The sample sits in the low bits of `in_data` and any bits above the width are ignored.
- R2: Bits leave MSB first. The half-frame with `frame_clk` low carries the left sample (tag `in_right` = 0), and the half with `frame_clk` high carries the right sample (tag 1).
- R3: With `fmt_delay` = 1 and `fmt_rjust` = 0, the MSB appears on the second bit clock of the half-frame. When the sample fills the whole half-frame, its LSB is sent on the first bit clock of the following half-frame.
- R4: With `fmt_delay` = 0 and `fmt_rjust` = 0, the MSB appears on the first bit clock of the half-frame.
- R5: With `fmt_rjust` = 1, the LSB is sent on the last bit clock of the half-frame and `fmt_delay` has no effect. A sample at least as wide as the half-frame starts on the first bit clock.
- R6: Every bit slot of a half-frame that carries no sample bit is sent as 0.
- R7: When `tx_on_rise` = 1, `sdo` changes only in the cycle after a `bclk_rise` strobe. When it is 0, `sdo` changes only after a `bclk_fall` strobe. `frame_clk` is sampled on the same strobe.
- R8: At each half-frame start the queue head is popped only if its tag matches the frame clock level. `in_ready` is low while the queue is full or enable is low.
- R9: If the queue is empty at a half-frame start, or the head carries the other channel's tag, that half-frame is sent as zeros and `underflow` is set. `underflow` then stays high until enable goes low.
- R10: While enable is low, the queue is emptied, and `sdo`, `in_ready` and `underflow` are held low. After enable rises, nothing is sent until the frame clock next turns low.
- R11: `slot_sel` sets the number of bit clocks per half-frame: 0 gives 16, 1 gives 32, and 2 or 3 gives 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the transmitter; low flushes and silences it |
| word_sel | input | 2 | Sample width code |
| slot_sel | input | 2 | Half-frame length code |
| fmt_delay | input | 1 | One-bit delay of the MSB (standard placement) |
| fmt_rjust | input | 1 | Right-justified placement |
| tx_on_rise | input | 1 | Selects the bit-clock strobe that advances the line |
| bclk_rise | input | 1 | One-cycle strobe at a bit-clock rising edge |
| bclk_fall | input | 1 | One-cycle strobe at a bit-clock falling edge |
| frame_clk | input | 1 | Frame clock level, low for left |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Queue accepts a sample |
| in_right | input | 1 | Channel tag of the offered sample, 1 for right |
| in_data | input | 32 | Offered sample, right-aligned |
| sdo | output | 1 | Serial data line |
| underflow | output | 1 | Sticky missing-sample flag |

## Verification
The assertions check, on every cycle, the properties that do not depend on the frame layout: the line is silent while disabled or still waiting for the first left half-frame, it does not move without the selected strobe, the underflow flag stays set once raised, nothing is popped from an empty queue, and the queue refuses samples while disabled. Only the bench scenarios can show bit placement. The bench sweeps every legal combination of width, half-frame length and placement, compares each serial bit against an arithmetic model (including the LSB that spills into the next half-frame), and drives the tag-mismatch, empty-queue, flush and full-queue cases.

// File: rtl/stx_pkg.sv
package stx_pkg;

    // Widest sample the datapath carries.
    localparam int unsigned SAMPLE_W = 32;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_SYNC,
        ST_LEAD,
        ST_SHIFT,
        ST_PAD
    } tx_state_t;

    typedef struct packed {
        logic                right;
        logic [SAMPLE_W-1:0] data;
    } tagged_sample_t;

endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 33
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [AW-1:0]    rd_ptr;
    logic [AW-1:0]    wr_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push;
    logic             do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

endmodule

// File: rtl/stx_layout.sv
module stx_layout
    import stx_pkg::*;
#(
    parameter int SLOT_MAX = 64,
    parameter int CW       = 7
) (
    input  logic [1:0]          word_sel,
    input  logic [1:0]          slot_sel,
    input  logic                fmt_delay,
    input  logic                fmt_rjust,
    input  logic [SAMPLE_W-1:0] raw,
    output logic [CW-1:0]       wbits,
    output logic [CW-1:0]       sbits,
    output logic [CW-1:0]       lead,
    output logic [SAMPLE_W-1:0] aligned
);
    always_comb begin
        // R1: width decode, reserved code 3 behaves as full width
        unique case (word_sel)
            2'd0:    wbits = CW'(16);
            2'd1:    wbits = CW'(24);
            default: wbits = CW'(SAMPLE_W);
        endcase

        // R11: half-frame length decode
        unique case (slot_sel)
            2'd0:    sbits = CW'(16);
            2'd1:    sbits = CW'(32);
            default: sbits = CW'(SLOT_MAX);
        endcase

        // R3 R4 R5: zero slots ahead of the MSB
        if (fmt_rjust) begin
            lead = (sbits > wbits) ? (sbits - wbits) : '0;
        end else begin
            lead = fmt_delay ? CW'(1) : '0;
        end

        // MSB-align the sample so that bits above the width drop out
        aligned = raw << (CW'(SAMPLE_W) - wbits);
    end

endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx
    import stx_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int SLOT_MAX   = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [1:0]          word_sel,
    input  logic [1:0]          slot_sel,
    input  logic                fmt_delay,
    input  logic                fmt_rjust,
    input  logic                tx_on_rise,
    input  logic                bclk_rise,
    input  logic                bclk_fall,
    input  logic                frame_clk,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic                in_right,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                sdo,
    output logic                underflow
);
    localparam int CW = $clog2(SLOT_MAX + 1);
    localparam int FW = $bits(tagged_sample_t);

    tx_state_t           state;
    tx_state_t           state_n;
    logic                act;
    logic                edge_seen;
    logic                go;
    logic                match;
    logic                spill;
    logic                lr_prev;
    logic                sdo_q;
    logic                sdo_n;
    logic                uf_q;
    logic [SAMPLE_W-1:0] word_q;
    logic [SAMPLE_W-1:0] word_n;
    logic [SAMPLE_W-1:0] new_word;
    logic [SAMPLE_W-1:0] aligned;
    logic [CW-1:0]       bits_left;
    logic [CW-1:0]       bits_n;
    logic [CW-1:0]       lead_left;
    logic [CW-1:0]       lead_n;
    logic [CW-1:0]       wbits;
    logic [CW-1:0]       sbits;
    logic [CW-1:0]       lead;
    logic                fifo_push;
    logic                fifo_pop;
    logic                fifo_empty;
    logic                fifo_full;
    tagged_sample_t      head;
    tagged_sample_t      wr_entry;

    // ---------------------------------------------------------------
    // Sample queue (R8, R10)
    // ---------------------------------------------------------------
    assign wr_entry  = '{right: in_right, data: in_data};
    assign in_ready  = enable && !fifo_full;
    assign fifo_push = in_valid && in_ready;
    assign fifo_pop  = go && match;

    stx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (FW)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!enable),
        .push  (fifo_push),
        .wdata (wr_entry),
        .pop   (fifo_pop),
        .rdata (head),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    stx_layout #(
        .SLOT_MAX (SLOT_MAX),
        .CW       (CW)
    ) u_layout (
        .word_sel  (word_sel),
        .slot_sel  (slot_sel),
        .fmt_delay (fmt_delay),
        .fmt_rjust (fmt_rjust),
        .raw       (head.data),
        .wbits     (wbits),
        .sbits     (sbits),
        .lead      (lead),
        .aligned   (aligned)
    );

    // ---------------------------------------------------------------
    // Strobe selection and half-frame detection (R7, R2)
    // ---------------------------------------------------------------
    always_comb begin
        act       = tx_on_rise ? bclk_rise : bclk_fall;
        edge_seen = act && (frame_clk != lr_prev);
        match     = !fifo_empty && (head.right == frame_clk);
        spill     = (state == ST_SHIFT) && (bits_left == CW'(1));
        new_word  = match ? aligned : '0;
    end

    always_comb begin
        unique case (state)
            ST_OFF:  go = 1'b0;
            ST_SYNC: go = edge_seen && !frame_clk;   // R10: first left half
            default: go = edge_seen;
        endcase
        if (!enable) begin
            go = 1'b0;
        end
    end

    // ---------------------------------------------------------------
    // Next-state and next-output logic
    // ---------------------------------------------------------------
    always_comb begin
        state_n = state;
        sdo_n   = sdo_q;
        word_n  = word_q;
        bits_n  = bits_left;
        lead_n  = lead_left;

        if (!enable) begin
            state_n = ST_OFF;
            sdo_n   = 1'b0;
            word_n  = '0;
            bits_n  = '0;
            lead_n  = '0;
        end else if (go) begin
            if (lead == '0) begin
                state_n = ST_SHIFT;
                sdo_n   = new_word[SAMPLE_W-1];
                word_n  = new_word << 1;
                bits_n  = wbits - CW'(1);
            end else begin
                state_n = ST_LEAD;
                sdo_n   = spill ? word_q[SAMPLE_W-1] : 1'b0;  // R3 carry-over
                word_n  = new_word;
                lead_n  = lead - CW'(1);
            end
        end else begin
            unique case (state)
                ST_OFF: begin
                    state_n = ST_SYNC;
                end
                ST_SYNC: begin
                    sdo_n = 1'b0;
                end
                ST_LEAD: begin
                    if (act) begin
                        if (lead_left == '0) begin
                            state_n = ST_SHIFT;
                            sdo_n   = word_q[SAMPLE_W-1];
                            word_n  = word_q << 1;
                            bits_n  = wbits - CW'(1);
                        end else begin
                            sdo_n  = 1'b0;
                            lead_n = lead_left - CW'(1);
                        end
                    end
                end
                ST_SHIFT: begin
                    if (act) begin
                        if (bits_left == '0) begin
                            state_n = ST_PAD;
                            sdo_n   = 1'b0;            // R6
                        end else begin
                            sdo_n  = word_q[SAMPLE_W-1];
                            word_n = word_q << 1;
                            bits_n = bits_left - CW'(1);
                        end
                    end
                end
                ST_PAD: begin
                    if (act) begin
                        sdo_n = 1'b0;                  // R6
                    end
                end
                default: begin
                    state_n = ST_OFF;
                end
            endcase
        end
    end

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_n;
        end
    end

    // ---------------------------------------------------------------
    // Output and datapath registers
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo_q     <= 1'b0;
            word_q    <= '0;
            bits_left <= '0;
            lead_left <= '0;
            lr_prev   <= 1'b0;
            uf_q      <= 1'b0;
        end else begin
            sdo_q     <= sdo_n;
            word_q    <= word_n;
            bits_left <= bits_n;
            lead_left <= lead_n;
            if (act) begin
                lr_prev <= frame_clk;
            end
            if (!enable) begin
                uf_q <= 1'b0;                          // R10
            end else if (go && !match) begin
                uf_q <= 1'b1;                          // R9
            end
        end
    end

    assign sdo       = sdo_q;
    assign underflow = uf_q;

endmodule

// File: rtl/stereo_ser_tx_chk.sv
module stereo_ser_tx_chk
    import stx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      enable,
    input logic      tx_on_rise,
    input logic      bclk_rise,
    input logic      bclk_fall,
    input logic      in_ready,
    input logic      sdo,
    input logic      underflow,
    input logic      fifo_pop,
    input logic      fifo_empty,
    input tx_state_t state
);
    logic act;
    assign act = tx_on_rise ? bclk_rise : bclk_fall;

    AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sdo); // R10

    AST_SYNC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SYNC) |-> !sdo); // R10

    AST_NO_READY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !in_ready); // R8

    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !act) |=> $stable(sdo)); // R7

    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && underflow) |=> underflow); // R9

    AST_UNDERFLOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !underflow); // R10

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty); // R8

endmodule

bind stereo_ser_tx stereo_ser_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .tx_on_rise (tx_on_rise),
    .bclk_rise  (bclk_rise),
    .bclk_fall  (bclk_fall),
    .in_ready   (in_ready),
    .sdo        (sdo),
    .underflow  (underflow),
    .fifo_pop   (fifo_pop),
    .fifo_empty (fifo_empty),
    .state      (state)
);

// File: tb/stereo_ser_tx_test.sv
module stereo_ser_tx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  word_sel = 2'd0;
    logic [1:0]  slot_sel = 2'd0;
    logic        fmt_delay = 1'b0;
    logic        fmt_rjust = 1'b0;
    logic        tx_on_rise = 1'b0;
    logic        bclk_rise = 1'b0;
    logic        bclk_fall = 1'b0;
    logic        frame_clk = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_right = 1'b0;
    logic [31:0] in_data = '0;
    logic        sdo;
    logic        underflow;

    int          checks = 0;
    int          errors = 0;
    int          cur_w;
    int          cur_s;
    int          cur_lead;
    logic [31:0] cur_mask;
    string       cur_tag;
    logic        carry;
    logic        prev_exp;

    always #2.5 clk = ~clk;   // 200 MHz

    stereo_ser_tx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .word_sel   (word_sel),
        .slot_sel   (slot_sel),
        .fmt_delay  (fmt_delay),
        .fmt_rjust  (fmt_rjust),
        .tx_on_rise (tx_on_rise),
        .bclk_rise  (bclk_rise),
        .bclk_fall  (bclk_fall),
        .frame_clk  (frame_clk),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_right   (in_right),
        .in_data    (in_data),
        .sdo        (sdo),
        .underflow  (underflow)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h (t=%0t)", req, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk(input int n);
        return 32'h5A00_0F0F ^ (32'(n) * 32'h9E37_79B1);
    endfunction

    task automatic set_cfg(input int ws, input int ss, input int md);
        word_sel  = 2'(ws);
        slot_sel  = 2'(ss);
        fmt_delay = (md != 1);
        fmt_rjust = (md == 2);
        cur_w     = (ws == 0) ? 16 : (ws == 1) ? 24 : 32;
        cur_s     = (ss == 0) ? 16 : (ss == 1) ? 32 : 64;
        cur_mask  = (cur_w == 32) ? 32'hFFFF_FFFF : ((32'd1 << cur_w) - 32'd1);
        if (md == 2) begin
            cur_lead = (cur_s > cur_w) ? cur_s - cur_w : 0;
            cur_tag  = "R1 R2 R5";
        end else if (md == 0) begin
            cur_lead = 1;
            cur_tag  = "R1 R2 R3";
        end else begin
            cur_lead = 0;
            cur_tag  = "R1 R2 R4";
        end
    endtask

    task automatic go_on();
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        carry    = 1'b0;
        prev_exp = 1'b0;
    endtask

    task automatic go_off();
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
        prev_exp = 1'b0;
        chk("R10 sdo off", 32'(sdo), 32'd0);
        chk("R10 ready off", 32'(in_ready), 32'd0);
        chk("R10 underflow off", 32'(underflow), 32'd0);
    endtask

    task automatic push(input logic right, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_right = right;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // One bit clock: rise strobe, then fall strobe, then an idle cycle.
    task automatic bit_step(input logic lr, input logic exp, input string req);
        @(negedge clk);
        frame_clk = lr;
        bclk_rise = 1'b1;
        @(negedge clk);
        bclk_rise = 1'b0;
        if (tx_on_rise) chk(req, 32'(sdo), 32'(exp));
        else            chk("R7 hold before fall", 32'(sdo), 32'(prev_exp));
        bclk_fall = 1'b1;
        @(negedge clk);
        bclk_fall = 1'b0;
        if (tx_on_rise) chk("R7 hold after rise", 32'(sdo), 32'(exp));
        else            chk(req, 32'(sdo), 32'(exp));
        prev_exp = exp;
    endtask

    task automatic preamble();
        bit_step(1'b1, 1'b0, "R10 sync wait");
        bit_step(1'b1, 1'b0, "R10 sync wait");
    endtask

    task automatic run_frame(input logic [31:0] dl, input logic hl,
                             input logic [31:0] dr, input logic hr);
        logic [31:0] wd;
        logic        e;
        string       tag;
        int          idx;
        for (int h = 0; h < 2; h++) begin
            if (h == 0) wd = hl ? (dl & cur_mask) : 32'd0;
            else        wd = hr ? (dr & cur_mask) : 32'd0;
            for (int q = 0; q < cur_s; q++) begin
                idx = q - cur_lead;
                if (q == 0 && cur_lead > 0) begin
                    e   = carry;
                    tag = "R3 carry";
                end else if (idx >= 0 && idx < cur_w) begin
                    e   = wd[cur_w - 1 - idx];
                    tag = cur_tag;
                end else begin
                    e   = 1'b0;
                    tag = "R6 R11";
                end
                bit_step(h[0], e, tag);
            end
            carry = (cur_lead + cur_w == cur_s + 1) ? wd[0] : 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset sdo", 32'(sdo), 32'd0);
        chk("R10 reset ready", 32'(in_ready), 32'd0);
        chk("R9 reset underflow", 32'(underflow), 32'd0);

        // Sweep every legal width / half-frame / placement combination.
        for (int ws = 0; ws < 3; ws++) begin
            for (int ss = 0; ss < 3; ss++) begin
                for (int md = 0; md < 3; md++) begin
                    set_cfg(ws, ss, md);
                    if (cur_w <= cur_s) begin
                        tx_on_rise = ((n / 4) % 2) == 1;
                        go_on();
                        push(1'b0, mk(n));
                        push(1'b1, mk(n + 1));
                        preamble();
                        run_frame(mk(n), 1'b1, mk(n + 1), 1'b1);
                        push(1'b0, mk(n + 2));
                        push(1'b1, mk(n + 3));
                        run_frame(mk(n + 2), 1'b1, mk(n + 3), 1'b1);
                        chk("R9 no underflow when fed", 32'(underflow), 32'd0);
                        go_off();
                        n += 4;
                    end
                end
            end
        end

        // Reserved width code behaves as 32 bits (R1), left-justified, 64 slots.
        set_cfg(2, 2, 1);
        word_sel   = 2'd3;
        tx_on_rise = 1'b0;
        go_on();
        push(1'b0, mk(500));
        push(1'b1, mk(501));
        preamble();
        run_frame(mk(500), 1'b1, mk(501), 1'b1);
        go_off();

        // Empty queue: zeros and sticky underflow (R9).
        set_cfg(0, 1, 0);
        tx_on_rise = 1'b1;
        go_on();
        preamble();
        run_frame(32'd0, 1'b0, 32'd0, 1'b0);
        chk("R9 underflow set on empty", 32'(underflow), 32'd1);
        bit_step(1'b0, 1'b0, "R9 zeros while starved");
        chk("R9 underflow sticky", 32'(underflow), 32'd1);
        go_off();

        // Tag mismatch: right sample at head during a left half (R8 R9).
        go_on();
        push(1'b1, mk(600));
        push(1'b0, mk(601));
        preamble();
        run_frame(32'd0, 1'b0, mk(600), 1'b1);
        chk("R9 underflow on mismatch", 32'(underflow), 32'd1);
        run_frame(mk(601), 1'b1, 32'd0, 1'b0);
        go_off();

        // Flush: samples queued before disable are dropped (R10).
        go_on();
        push(1'b0, mk(700));
        push(1'b1, mk(701));
        go_off();
        go_on();
        preamble();
        run_frame(32'd0, 1'b0, 32'd0, 1'b0);
        chk("R10 flushed queue starves", 32'(underflow), 32'd1);
        go_off();

        // Full queue refuses more (R8), then drains in order.
        set_cfg(1, 1, 2);
        tx_on_rise = 1'b0;
        go_on();
        push(1'b0, mk(800));
        push(1'b1, mk(801));
        push(1'b0, mk(802));
        push(1'b1, mk(803));
        @(negedge clk);
        chk("R8 ready low when full", 32'(in_ready), 32'd0);
        preamble();
        run_frame(mk(800), 1'b1, mk(801), 1'b1);
        @(negedge clk);
        chk("R8 ready after drain", 32'(in_ready), 32'd1);
        run_frame(mk(802), 1'b1, mk(803), 1'b1);
        chk("R9 no underflow", 32'(underflow), 32'd0);
        go_off();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule